// File: doc/BRIEF.md
# Transmit Queue to Channel Dispatcher

This block keeps the state of a set of circular transmit rings and turns it into frame requests for a smaller set of transmit FIFO channels. For every ring the host supplies a write index. The dispatcher owns the matching read index and steps it forward each time a request for that ring is taken. Each ring carries a small configuration word. The word holds an active flag, the channel the ring feeds, a window-space flag and a block-ack/in-order mode bit. Every write to that word carries its own per-bit enables.

Each channel serves every active ring mapped to it that holds pending entries. The channel takes turns among those rings and issues at most one request per cycle. A channel-enable mask can silence any channel. An empty-override register can force rings to look empty while they are being re-initialized. A per-ring interrupt mask turns each read-index step into a one-cycle interrupt pulse. A monitor port returns one ring's configuration word and read index, so the host can read them back.

Top module: `txq_dispatch`

## Requirements
- R1: After reset no channel requests, no interrupt is raised, every configuration word and read index reads 0, and all channels are disabled.
- R2: A configuration write to ring q uses data bits 9..0 and enable bits 19..10. Bit i of the word takes data bit i only when enable bit 10+i is 1; all other bits keep their value. Field positions: bit 0 active, bits 4..1 channel, bit 5 window-space, bit 8 block-ack mode.
- R3: Ring q is eligible when it is active, its read index differs from its write index, and it is not forced empty. Channel c then raises req_valid[c], with req_queue slice c naming the ring and req_index slice c giving that ring's read index.
- R4: When req_valid[c] and chan_ready[c] are both 1 at a clock edge, the granted ring's read index is one higher after that edge. Without chan_ready[c] the index holds.
- R5: Within a channel, the ring after the one last granted (in ascending order, wrapping) wins. After reset the search starts at ring 0.
- R6: A channel whose enable bit is 0 raises no request and advances no read index. Channel-field values 8..15 reach no channel.
- R7: An empty-override write sets ring q's forced-empty flag to data bit q when mask bit 16+q is 1. A write-index write to ring q clears the flag, unless an override write to q happens in the same cycle, which wins.
- R8: If ring q's interrupt mask bit is 1 at the edge where its read index advances, irq[q] is 1 for the following cycle only.
- R9: A host write to a read index takes priority over an advance of that index in the same cycle.
- R10: Different channels grant independently in the same cycle.
- R11: Read indexes wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_we | input | 1 | Configuration word write strobe |
| stat_q | input | 4 | Ring addressed by the configuration write |
| stat_wdata | input | 20 | Enables [19:10] and data [9:0] |
| wr_we | input | 1 | Write-index write strobe |
| wr_q | input | 4 | Ring for the write-index write |
| wr_data | input | 8 | New write index |
| rd_we | input | 1 | Read-index write strobe |
| rd_q | input | 4 | Ring for the read-index write |
| rd_data | input | 8 | New read index |
| empty_we | input | 1 | Empty-override write strobe |
| empty_wdata | input | 32 | Masks [31:16], forced-empty values [15:0] |
| imask_we | input | 1 | Interrupt-mask write strobe |
| imask_wdata | input | 16 | Interrupt enable per ring |
| chen_we | input | 1 | Channel-enable write strobe |
| chen_wdata | input | 8 | Enable per channel |
| chan_ready | input | 8 | Channel accepts a request this cycle |
| req_valid | output | 8 | Request present per channel |
| req_queue | output | 32 | Granted ring, 4 bits per channel |
| req_index | output | 64 | Read index of granted ring, 8 bits per channel |
| irq | output | 16 | Read-index advance interrupt per ring |
| mon_q | input | 4 | Ring selected for readback |
| mon_status | output | 10 | Configuration word of mon_q |
| mon_rdidx | output | 8 | Read index of mon_q |

## Verification
Writes and read-index advances land on the clock edge where they are presented. The request outputs and the readback are combinational from the state registers, so they show the new values in the same cycle that follows that edge. The interrupt pulse passes through one more register and appears in the cycle after the advancing edge. The bench drives inputs on the falling edge and samples one nanosecond later. At each rising edge a reference model steps forward, so requests and readback are compared with the updated model in the next cycle. Expected interrupts are held over and compared one cycle later.

// File: rtl/txq_dispatch.sv
module txq_dispatch #(
  parameter int NQ  = 16,
  parameter int NCH = 8,
  parameter int IW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_we,
  input  logic [$clog2(NQ)-1:0] stat_q,
  input  logic [19:0]       stat_wdata,
  input  logic              wr_we,
  input  logic [$clog2(NQ)-1:0] wr_q,
  input  logic [IW-1:0]     wr_data,
  input  logic              rd_we,
  input  logic [$clog2(NQ)-1:0] rd_q,
  input  logic [IW-1:0]     rd_data,
  input  logic              empty_we,
  input  logic [2*NQ-1:0]   empty_wdata,
  input  logic              imask_we,
  input  logic [NQ-1:0]     imask_wdata,
  input  logic              chen_we,
  input  logic [NCH-1:0]    chen_wdata,
  input  logic [NCH-1:0]    chan_ready,
  output logic [NCH-1:0]    req_valid,
  output logic [NCH*$clog2(NQ)-1:0] req_queue,
  output logic [NCH*IW-1:0] req_index,
  output logic [NQ-1:0]     irq,
  input  logic [$clog2(NQ)-1:0] mon_q,
  output logic [9:0]        mon_status,
  output logic [IW-1:0]     mon_rdidx
);
  localparam int QW = $clog2(NQ);
  localparam int CW = $clog2(NCH);

  logic [9:0]    stat   [NQ];
  logic [IW-1:0] wr_idx [NQ];
  logic [IW-1:0] rd_idx [NQ];
  logic [QW-1:0] rr_last [NCH];
  logic [NQ-1:0] force_empty, irq_mask, elig, adv;
  logic [NCH-1:0] ch_en, gv;
  logic [QW-1:0] gq [NCH];

  always_comb
    for (int q = 0; q < NQ; q++)
      elig[q] = stat[q][0] && (rd_idx[q] != wr_idx[q]) && !force_empty[q];

  always_comb begin
    logic [QW-1:0] cand;
    gv = '0;
    for (int c = 0; c < NCH; c++) begin
      gq[c] = '0;
      for (int k = 1; k <= NQ; k++) begin
        cand = rr_last[c] + QW'(k);
        if (!gv[c] && ch_en[c] && elig[cand] && stat[cand][4:1] == 4'(c)) begin
          gv[c] = 1'b1;
          gq[c] = cand;
        end
      end
    end
  end

  always_comb begin
    adv = '0;
    for (int c = 0; c < NCH; c++)
      if (gv[c] && chan_ready[c]) adv[gq[c]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        stat[q]   <= '0;
        wr_idx[q] <= '0;
        rd_idx[q] <= '0;
      end
      for (int c = 0; c < NCH; c++) rr_last[c] <= QW'(NQ - 1);
      force_empty <= '0;
      irq_mask    <= '0;
      ch_en       <= '0;
      irq         <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (stat_we && stat_q == QW'(q))
          stat[q] <= (stat[q] & ~stat_wdata[19:10]) | (stat_wdata[9:0] & stat_wdata[19:10]);
        if (wr_we && wr_q == QW'(q)) wr_idx[q] <= wr_data;
        if (rd_we && rd_q == QW'(q)) rd_idx[q] <= rd_data;
        else if (adv[q])             rd_idx[q] <= rd_idx[q] + 1'b1;
        if (empty_we && empty_wdata[NQ+q]) force_empty[q] <= empty_wdata[q];
        else if (wr_we && wr_q == QW'(q))  force_empty[q] <= 1'b0;
      end
      for (int c = 0; c < NCH; c++)
        if (gv[c] && chan_ready[c]) rr_last[c] <= gq[c];
      if (imask_we) irq_mask <= imask_wdata;
      if (chen_we)  ch_en    <= chen_wdata;
      irq <= adv & irq_mask;
    end
  end

  assign req_valid  = gv;
  assign mon_status = stat[mon_q];
  assign mon_rdidx  = rd_idx[mon_q];

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign req_queue[c*QW +: QW] = gq[c];
    assign req_index[c*IW +: IW] = rd_idx[gq[c]];
  end

  for (genvar q = 0; q < NQ; q++) begin : g_chk
    assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && stat_q == QW'(q)) |=>
        (((stat[q] ^ $past(stat[q])) & ~$past(stat_wdata[19:10])) == 10'd0));
    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv[q] && !(rd_we && rd_q == QW'(q))) |=> rd_idx[q] == IW'($past(rd_idx[q]) + 1'b1));
    assert_chan_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx[q] != $past(rd_idx[q]) && !$past(rd_we && rd_q == QW'(q))) |->
        $past(stat[q][4:1] < 4'(NCH) && ch_en[stat[q][CW:1]] && stat[q][0]));
    assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[q] |-> $past(irq_mask[q]) && $past(stat[q][0]));
  end
endmodule

// File: tb/txq_dispatch_bench.sv
module txq_dispatch_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stat_we, wr_we, rd_we, empty_we, imask_we, chen_we;
  logic [3:0] stat_q, wr_q, rd_q, mon_q;
  logic [19:0] stat_wdata;
  logic [7:0] wr_data, rd_data, chen_wdata, chan_ready;
  logic [31:0] empty_wdata;
  logic [15:0] imask_wdata, irq;
  logic [7:0] req_valid;
  logic [31:0] req_queue;
  logic [63:0] req_index;
  logic [9:0] mon_status;
  logic [7:0] mon_rdidx;

  txq_dispatch u_txq_dispatch (.*);

  always #4 clk = ~clk;

  int total = 0, fails = 0;
  logic [9:0] m_stat [16];
  logic [7:0] m_wr [16], m_rd [16];
  logic [3:0] m_last [8];
  logic [15:0] m_fe, m_mask, m_irq;
  logic [7:0] m_chen, e_v;
  logic [3:0] e_q [8];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void grants();
    for (int c = 0; c < 8; c++) begin
      e_v[c] = 1'b0; e_q[c] = 4'd0;
      for (int k = 1; k <= 16; k++) begin
        logic [3:0] n;
        n = m_last[c] + 4'(k);
        if (!e_v[c] && m_chen[c] && m_stat[n][0] && m_rd[n] != m_wr[n] && !m_fe[n]
            && m_stat[n][4:1] == 4'(c)) begin
          e_v[c] = 1'b1; e_q[c] = n;
        end
      end
    end
  endfunction

  function automatic void step_model();
    logic [15:0] a;
    a = '0;
    for (int c = 0; c < 8; c++)
      if (e_v[c] && chan_ready[c]) begin a[e_q[c]] = 1'b1; m_last[c] = e_q[c]; end
    m_irq = a & m_mask;
    for (int q = 0; q < 16; q++) begin
      if (stat_we && stat_q == 4'(q))
        for (int b = 0; b < 10; b++) if (stat_wdata[10+b]) m_stat[q][b] = stat_wdata[b];
      if (rd_we && rd_q == 4'(q)) m_rd[q] = rd_data;
      else if (a[q]) m_rd[q] = m_rd[q] + 8'd1;
      if (empty_we && empty_wdata[16+q]) m_fe[q] = empty_wdata[q];
      else if (wr_we && wr_q == 4'(q)) m_fe[q] = 1'b0;
      if (wr_we && wr_q == 4'(q)) m_wr[q] = wr_data;
    end
    if (imask_we) m_mask = imask_wdata;
    if (chen_we) m_chen = chen_wdata;
  endfunction

  task automatic idle();
    stat_we = 0; wr_we = 0; rd_we = 0; empty_we = 0; imask_we = 0; chen_we = 0;
  endtask

  task automatic cyc(input string tag, input int n);
    repeat (n) begin
      grants();
      #1;
      for (int c = 0; c < 8; c++) begin
        check(req_valid[c] === e_v[c], tag, 64'(req_valid[c]), 64'(e_v[c]));
        if (e_v[c]) begin
          check(req_queue[c*4 +: 4] === e_q[c], tag, 64'(req_queue[c*4 +: 4]), 64'(e_q[c]));
          check(req_index[c*8 +: 8] === m_rd[e_q[c]], tag, 64'(req_index[c*8 +: 8]), 64'(m_rd[e_q[c]]));
        end
      end
      check(irq === m_irq, "R8", 64'(irq), 64'(m_irq));
      check(mon_status === m_stat[mon_q], "R2", 64'(mon_status), 64'(m_stat[mon_q]));
      check(mon_rdidx === m_rd[mon_q], "R4", 64'(mon_rdidx), 64'(m_rd[mon_q]));
      @(posedge clk);
      step_model();
      @(negedge clk);
      idle();
    end
  endtask

  task automatic wstat(input int q, input logic [9:0] en, input logic [9:0] d);
    stat_we = 1; stat_q = 4'(q); stat_wdata = {en, d};
  endtask
  task automatic wwr(input int q, input int v);
    wr_we = 1; wr_q = 4'(q); wr_data = 8'(v);
  endtask

  function automatic logic [9:0] cfg(input int ch);
    return {5'd0, 1'b0, 4'(ch)} << 1 | 10'd1;
  endfunction

  initial begin
    idle();
    stat_q = 0; wr_q = 0; rd_q = 0; mon_q = 0; stat_wdata = 0; wr_data = 0; rd_data = 0;
    empty_wdata = 0; imask_wdata = 0; chen_wdata = 0; chan_ready = 0;
    for (int q = 0; q < 16; q++) begin m_stat[q] = 0; m_wr[q] = 0; m_rd[q] = 0; end
    for (int c = 0; c < 8; c++) m_last[c] = 4'd15;
    m_fe = 0; m_mask = 0; m_irq = 0; m_chen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check(req_valid === 8'd0 && irq === 16'd0 && mon_status === 10'd0, "R1",
          {req_valid, irq, 6'd0, mon_status}, 64'd0);
    cyc("R1", 1);
    wstat(0, 10'h3FF, cfg(1)); cyc("R2", 1);
    wstat(0, 10'h000, 10'h3FF); cyc("R2", 1);
    wstat(0, 10'h100, 10'h3FF); cyc("R2", 1);
    #1 check(mon_status === 10'h103, "R2", 64'(mon_status), 64'h103);
    chen_we = 1; chen_wdata = 8'hFF; imask_we = 1; imask_wdata = 16'h0001;
    wwr(0, 3); cyc("R3", 1);
    cyc("R4", 2);
    chan_ready = 8'hFF; cyc("R8", 5);
    wstat(1, 10'h3FF, cfg(1)); cyc("R5", 1);
    wstat(2, 10'h3FF, cfg(1)); cyc("R5", 1);
    chan_ready = 0;
    wwr(1, 2); cyc("R5", 1);
    wwr(2, 2); cyc("R5", 1);
    wwr(0, 5); cyc("R5", 1);
    chan_ready = 8'h02; cyc("R5", 7);
    wwr(0, 8); cyc("R6", 1);
    chen_we = 1; chen_wdata = 8'hFD; cyc("R6", 3);
    chen_we = 1; chen_wdata = 8'hFF; empty_we = 1; empty_wdata = 32'h0001_0001; cyc("R7", 3);
    wwr(0, 9); cyc("R7", 3);
    rd_we = 1; rd_q = 0; rd_data = 8'd255; wwr(1, 1); cyc("R9", 1);
    wwr(0, 1); cyc("R11", 4);
    wstat(3, 10'h3FF, cfg(2)); cyc("R10", 1);
    wwr(3, 4); wstat(4, 10'h3FF, cfg(9)); cyc("R10", 1);
    wwr(4, 4); chan_ready = 8'hFF; cyc("R10", 4);
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      chan_ready = 8'($urandom);
      mon_q = 4'($urandom);
      if ($urandom % 8 == 0) begin
        logic [9:0] d;
        d = 10'($urandom);
        if ($urandom % 4 != 0) d[4] = 1'b0;
        wstat($urandom % 16, 10'($urandom), d);
      end
      if ($urandom % 3 == 0) wwr($urandom % 16, $urandom);
      if ($urandom % 32 == 0) begin rd_we = 1; rd_q = 4'($urandom); rd_data = 8'($urandom); end
      if ($urandom % 40 == 0) begin empty_we = 1; empty_wdata = $urandom; end
      if ($urandom % 30 == 0) begin imask_we = 1; imask_wdata = 16'($urandom); end
      if ($urandom % 50 == 0) begin chen_we = 1; chen_wdata = ($urandom % 2) ? 8'hFF : 8'($urandom); end
      cyc("R3", 1);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule